// File: doc/BRIEF.md
# Dual Data Pointer Select Register

This block holds two 16-bit data pointers and a one-byte auxiliary control register that sits at a fixed special-function address. Software writes bit 0 of that register to choose which pointer is active. The active pointer is always visible on the output. Only the active pointer accepts a parallel load or a step of plus one.

The same byte also holds a general-purpose flag and an enable that maps a boot ROM into the top of the code space. Bit 2 of the byte is tied to zero. Because of that, reading the byte, adding one and writing the result back flips only the pointer select. The flag in bit 3 stays as it was.

The boot-map output goes to the code address decoder. It is high only when the enable is set and the fetch address falls in the top 2 KiB window.

Top module: `aux_dptr_select`

## Requirements
- R1: After reset the control byte reads 0x00, the active pointer is 0x0000 and boot_map is low.
- R2: Bit 0 of the control byte selects the active pointer (0 selects pointer 0, 1 selects pointer 1). A write takes effect on the dp_active output from the cycle after the write edge.
- R3: Bit 2 of the control byte always reads 0, whatever value is written to it.
- R4: Bit 3 of the control byte is a user flag. It reads back the last value written to it.
- R5: If the read value plus one is written back, bit 0 toggles and bit 3 keeps its value, whatever bit 0 was before.
- R6: boot_map is high exactly when bit 5 of the control byte is 1 and fetch_addr is 0xF800 or above. It follows fetch_addr in the same cycle.
- R7: Bits 7, 6, 4 and 1 of the control byte read 0.
- R8: dp_load and dp_inc act only on the pointer selected before the clock edge. dp_load takes priority over dp_inc. An increment of 0xFFFF wraps to 0x0000. A pointer that is not selected keeps its value.
- R9: A write to any address other than 0xA2 leaves the control byte unchanged. A read at any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data (combinational) |
| dp_load | input | 1 | Load the selected pointer |
| dp_load_val | input | 16 | Value to load |
| dp_inc | input | 1 | Add one to the selected pointer |
| dp_active | output | 16 | Value of the selected pointer |
| fetch_addr | input | 16 | Current code fetch address |
| boot_map | output | 1 | Boot ROM mapped for this fetch |

## Verification
A register write or a pointer load or increment shows up on sfr_rdata and dp_active one clock edge later. boot_map and the read mux are combinational, so they respond within the same cycle as their inputs. The bench drives inputs just after the falling edge and compares every output with its behavioural model shortly afterwards. The model advances only on the rising edge, so each expected value matches the design's one-register latency. The increment trick is exercised from both select states, with the flag set and with it clear.

// File: rtl/aux_ptr_pkg.sv
`timescale 1ns/1ps
// Package: shared bit positions and control-state type for the pointer
// select register. Assumes an 8-bit special-function data path.
package aux_ptr_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned SEL_POS   = 0;
    localparam int unsigned ZERO_POS  = 2;
    localparam int unsigned FLAG_POS  = 3;
    localparam int unsigned BOOT_POS  = 5;

    typedef struct packed {
        logic boot_en;
        logic flag;
        logic sel;
    } ctrl_t;
endpackage

// File: rtl/aux_ctrl_reg.sv
`timescale 1ns/1ps
// Control byte: holds select, user flag and boot enable. Bit 2 and the
// reserved bits are not stored and read as zero, which makes read+1
// writes flip only the select. Assumes a single write strobe per cycle.
module aux_ctrl_reg
    import aux_ptr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] REG_ADDR = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output ctrl_t             ctrl
);
    logic hit;

    // Address match for both read and write.
    always_comb hit = (addr == REG_ADDR);

    // Store the three writable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr && hit) begin
            ctrl.sel     <= wdata[SEL_POS];
            ctrl.flag    <= wdata[FLAG_POS];
            ctrl.boot_en <= wdata[BOOT_POS];
        end
    end

    // Assemble the read byte; all unstored bits read zero.
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[SEL_POS]  = ctrl.sel;
            rdata[ZERO_POS] = 1'b0;
            rdata[FLAG_POS] = ctrl.flag;
            rdata[BOOT_POS] = ctrl.boot_en;
        end
    end
endmodule

// File: rtl/aux_dptr_bank.sv
`timescale 1ns/1ps
// Bank of data pointers. Only the pointer named by sel loads or
// increments; load wins over increment. Assumes sel is registered.
module aux_dptr_bank #(
    parameter int unsigned PTR_W   = 16,
    parameter int unsigned NUM_PTR = 2,
    localparam int unsigned SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] active
);
    logic [PTR_W-1:0] ptr_q [NUM_PTR];

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        // One pointer register, updated only while selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else if (sel == SEL_W'(g)) begin
                if (load)     ptr_q[g] <= load_val;
                else if (inc) ptr_q[g] <= ptr_q[g] + PTR_W'(1);
            end
        end
    end

    // Output mux for the selected pointer.
    always_comb active = ptr_q[sel];
endmodule

// File: rtl/aux_boot_window.sv
`timescale 1ns/1ps
// Boot window decode: flags fetches at or above BASE when enabled.
// Assumes BASE is the start of a window that runs to the top of space.
module aux_boot_window #(
    parameter int unsigned     ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hF800
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    output logic              mapped
);
    // Combinational range compare.
    always_comb mapped = enable && (addr >= BASE);
endmodule

// File: rtl/aux_dptr_select.sv
`timescale 1ns/1ps
// Top: dual data pointer with byte-wide control register and boot
// window decode. Assumes synchronous active-low reset and one master.
module aux_dptr_select
    import aux_ptr_pkg::*;
#(
    parameter int unsigned       PTR_W     = 16,
    parameter logic [BYTE_W-1:0] REG_ADDR  = 8'hA2,
    parameter logic [PTR_W-1:0]  BOOT_BASE = 16'hF800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_wr,
    input  logic [BYTE_W-1:0] sfr_addr,
    input  logic [BYTE_W-1:0] sfr_wdata,
    output logic [BYTE_W-1:0] sfr_rdata,
    input  logic              dp_load,
    input  logic [PTR_W-1:0]  dp_load_val,
    input  logic              dp_inc,
    output logic [PTR_W-1:0]  dp_active,
    input  logic [PTR_W-1:0]  fetch_addr,
    output logic              boot_map
);
    ctrl_t ctrl;

    aux_ctrl_reg #(.REG_ADDR(REG_ADDR)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(sfr_wr), .addr(sfr_addr),
        .wdata(sfr_wdata), .rdata(sfr_rdata), .ctrl(ctrl)
    );

    aux_dptr_bank #(.PTR_W(PTR_W), .NUM_PTR(2)) i_bank (
        .clk(clk), .rst_n(rst_n), .sel(ctrl.sel), .load(dp_load),
        .load_val(dp_load_val), .inc(dp_inc), .active(dp_active)
    );

    aux_boot_window #(.ADDR_W(PTR_W), .BASE(BOOT_BASE)) i_boot (
        .enable(ctrl.boot_en), .addr(fetch_addr), .mapped(boot_map)
    );
endmodule

// File: rtl/aux_dptr_select_chk.sv
`timescale 1ns/1ps
// Checker for aux_dptr_select, attached by bind. Observes ports only.
module aux_dptr_select_chk #(
    parameter int unsigned PTR_W     = 16,
    parameter logic [7:0]  REG_ADDR  = 8'hA2,
    parameter logic [15:0] BOOT_BASE = 16'hF800
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sfr_wr,
    input logic [7:0]       sfr_addr,
    input logic [7:0]       sfr_wdata,
    input logic [7:0]       sfr_rdata,
    input logic             dp_load,
    input logic [PTR_W-1:0] dp_load_val,
    input logic             dp_inc,
    input logic [PTR_W-1:0] dp_active,
    input logic [PTR_W-1:0] fetch_addr,
    input logic             boot_map
);
    logic wr_hit;
    always_comb wr_hit = sfr_wr && (sfr_addr == REG_ADDR);

    p_bit2_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rdata[2] == 1'b0);

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rdata[7:6] == 2'b00) && (sfr_rdata[4] == 1'b0) && (sfr_rdata[1] == 1'b0));

    p_boot_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_map |-> (fetch_addr >= BOOT_BASE));

    p_hold_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_load && !dp_inc && !wr_hit) |=> $stable(dp_active));

    p_step_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_inc && !dp_load && !wr_hit) |=> dp_active == $past(dp_active) + PTR_W'(1));

    p_load_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_load && !wr_hit) |=> dp_active == $past(dp_load_val));

    p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != REG_ADDR) |-> sfr_rdata == 8'h00);
endmodule

bind aux_dptr_select aux_dptr_select_chk #(
    .PTR_W(PTR_W), .REG_ADDR(REG_ADDR), .BOOT_BASE(BOOT_BASE)
) i_chk (.*);

// File: tb/test_aux_dptr_select.sv
`timescale 1ns/1ps
// Bench for aux_dptr_select: behavioural model compared every cycle.
module test_aux_dptr_select;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sfr_wr;
    logic [7:0]  sfr_addr;
    logic [7:0]  sfr_wdata;
    logic [7:0]  sfr_rdata;
    logic        dp_load;
    logic [15:0] dp_load_val;
    logic        dp_inc;
    logic [15:0] dp_active;
    logic [15:0] fetch_addr;
    logic        boot_map;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // model state
    int m_sel, m_flag, m_boot;
    int m_dp [2];

    always #2.5 clk = ~clk;

    aux_dptr_select i_aux_dptr_select (.*);

    // Reference update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_sel = 0; m_flag = 0; m_boot = 0; m_dp[0] = 0; m_dp[1] = 0;
        end else begin
            if (dp_load)     m_dp[m_sel] = dp_load_val;
            else if (dp_inc) m_dp[m_sel] = (m_dp[m_sel] + 1) % 65536;
            if (sfr_wr && sfr_addr == 8'hA2) begin
                m_sel  = sfr_wdata[0];
                m_flag = sfr_wdata[3];
                m_boot = sfr_wdata[5];
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        if (sfr_addr != 8'hA2) return 8'h00;
        return {2'b00, 1'(m_boot), 1'b0, 1'(m_flag), 2'b00, 1'(m_sel)};
    endfunction

    task automatic cmp(string tag);
        logic [7:0]  er = exp_rd();
        logic [15:0] ea = 16'(m_dp[m_sel]);
        logic        eb = (m_boot != 0) && (fetch_addr >= 16'hF800);
        checks++;
        if (sfr_rdata !== er || dp_active !== ea || boot_map !== eb) begin
            failures++;
            $display("FAIL %s: rdata=%h/%h active=%h/%h boot_map=%b/%b (actual/expected)",
                     tag, sfr_rdata, er, dp_active, ea, boot_map, eb);
        end
    endtask

    // Finish one cycle: compare, then move to next falling edge.
    task automatic tick(string tag);
        #1 cmp(tag);
        @(negedge clk);
        sfr_wr = 0; dp_load = 0; dp_inc = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
        sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
        tick(tag);
        sfr_addr = 8'hA2;
        tick(tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        while (!done && cycles < 100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected done", cycles);
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 0; sfr_wr = 0; sfr_addr = 8'hA2; sfr_wdata = 0;
        dp_load = 0; dp_load_val = 0; dp_inc = 0; fetch_addr = 16'hFFFF;
        m_sel = 0; m_flag = 0; m_boot = 0; m_dp[0] = 0; m_dp[1] = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        tick("R1 reset state");

        // R8: load and step pointer 0
        dp_load = 1; dp_load_val = 16'h1234; tick("R8 load p0");
        dp_inc = 1; tick("R8 inc p0");
        dp_load = 1; dp_inc = 1; dp_load_val = 16'h00AA; tick("R8 load priority");
        tick("R8 hold");

        // R2: select pointer 1, load it, pointer 0 untouched
        wr(8'hA2, 8'h01, "R2 select p1");
        dp_load = 1; dp_load_val = 16'hFFFF; tick("R8 load p1");
        dp_inc = 1; tick("R8 wrap p1");
        wr(8'hA2, 8'h00, "R2 select p0 kept");

        // R3/R7: write all ones
        wr(8'hA2, 8'hFF, "R3 R7 all ones");
        wr(8'hA2, 8'h00, "R3 clear");

        // R4 flag
        wr(8'hA2, 8'h08, "R4 flag set");
        wr(8'hA2, 8'h00, "R4 flag clear");

        // R5: read+1 writeback from each state, flag set and clear
        for (int f = 0; f < 2; f++) begin
            wr(8'hA2, f ? 8'h08 : 8'h00, "R5 prep");
            for (int k = 0; k < 3; k++) begin
                #1 v = sfr_rdata;
                wr(8'hA2, v + 8'd1, "R5 increment toggle");
            end
        end

        // R6 boot window edges
        wr(8'hA2, 8'h20, "R6 enable");
        fetch_addr = 16'hF7FF; tick("R6 below base");
        fetch_addr = 16'hF800; tick("R6 at base");
        fetch_addr = 16'h0000; tick("R6 low");
        wr(8'hA2, 8'h00, "R6 disable");
        fetch_addr = 16'hF800; tick("R6 disabled");

        // R9 other address
        wr(8'hA3, 8'h29, "R9 foreign write");
        sfr_addr = 8'h10; tick("R9 foreign read");
        sfr_addr = 8'hA2; tick("R9 unchanged");

        // R1 reset mid-run
        wr(8'hA2, 8'h29, "R1 prep");
        rst_n = 0; tick("R1 in reset");
        rst_n = 1; tick("R1 after reset");

        done = 1;
        summary();
    end
endmodule